// File: doc/BRIEF.md
# Camera Receiver Interrupt Aggregator

This block collects one-cycle event pulses from a camera receiver's datapath and holds each of them in a sticky bit of an interrupt status register. Software reads the status word, then clears the bits it has handled by writing ones to them. A per-bit enable register and a single global enable decide whether any pending bit drives the interrupt line.

Access is through a plain register port. A write is one cycle with `wr_en_i` high, an address and a data word. Reads are combinational from `addr_i`. There are three locations. The control word at 0x20 holds the global enable in bit 0. The status word is at 0x24. The enable word is at 0x28. Bits 31:23 of the status and enable words are not implemented.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status word, the enable word and the global enable are all zero, and `irq_o` is low.
- R2: An event pulse on `evt_i[n]` for an implemented bit n sets status bit n on the next clock edge. The bit stays set after the pulse ends.
- R3: A write to offset 0x24 clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R4: When an event and a write-1 clear hit the same status bit in the same cycle, the bit is set after that edge.
- R5: `irq_o` is high exactly when the global enable is 1 and at least one bit is set in both the status word and the enable word.
- R6: While the global enable (bit 0 at offset 0x20) is 0, `irq_o` stays low whatever the status and enable words hold.
- R7: Bits 31:23 of the status and enable words always read as zero. Writes and events on those bit positions have no effect.
- R8: The control word is at offset 0x20, the status word at 0x24 and the enable word at 0x28. A read from any other offset returns zero, and a write to any other offset changes no register.
- R9: Status bit n follows event input n. Bit 22 reports word-count corruption, bit 21 an incorrect lane configuration, bit 20 a full short-packet FIFO, and bit 10 a corrected single-bit header ECC error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | One-cycle event pulses, one per status bit |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset, used for both reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt line |

## Verification
A datapath event and a software write-1 clear can land on the same status bit in the same clock cycle. The bench first sets bit 21. It then raises `evt_i[21]` in the same cycle as a write of that bit to 0x24, and it expects the bit to read back as set. A long random phase puts events and clears on overlapping bits many times over. A behavioural model that gives the set priority checks `rdata_o` and `irq_o` on every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_ADDR_W = 8;
  localparam logic [REG_ADDR_W-1:0] OFS_CTRL = 8'h20;
  localparam logic [REG_ADDR_W-1:0] OFS_STAT = 8'h24;
  localparam logic [REG_ADDR_W-1:0] OFS_EN   = 8'h28;
  localparam int unsigned BIT_WC_CORRUPT = 22;
  localparam int unsigned BIT_LANE_CFG   = 21;
  localparam int unsigned BIT_SPKT_FULL  = 20;
  localparam int unsigned BIT_ECC_FIXED  = 10;
  localparam int unsigned BIT_GLOBAL_EN  = 0;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;   // set beats clear
        else if (clr_i[i]) q <= 1'b0;
      assign stat_o[i] = q;
    end else begin : g_rsvd
      assign stat_o[i] = 1'b0;
    end
  end

  assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_o & $past(set_i & MASK)) == $past(set_i & MASK)));
  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(stat_o) & ~$past(clr_i) & ~stat_o) == '0));
  assert_only_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_o & ~$past(stat_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/irq_rw_reg.sv
module irq_rw_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= wdata_i & MASK;
  assign q_o = q;

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
  assert_rsvd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((q_o & ~MASK) == '0));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] en_i,
  input  logic         gen_en_i,
  output logic         irq_o
);
  assign irq_o = gen_en_i & (|(stat_i & en_i));

  assert_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_en_i |-> !irq_o);
  assert_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((stat_i & en_i) != '0));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] IMPL_MASK = 32'h007F_FFFF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [W-1:0]          evt_i,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [W-1:0]          wdata_i,
  output logic [W-1:0]          rdata_o,
  output logic                  irq_o
);
  logic [W-1:0] stat, en, clr;
  logic [0:0]   ctrl;
  logic         we_stat, we_en, we_ctrl;

  assign we_stat = wr_en_i && (addr_i == OFS_STAT);
  assign we_en   = wr_en_i && (addr_i == OFS_EN);
  assign we_ctrl = wr_en_i && (addr_i == OFS_CTRL);
  assign clr     = we_stat ? wdata_i : '0;

  irq_status_reg #(.W(W), .MASK(IMPL_MASK)) u_stat (
    .clk_i, .rst_ni, .set_i(evt_i), .clr_i(clr), .stat_o(stat));

  irq_rw_reg #(.W(W), .MASK(IMPL_MASK)) u_en (
    .clk_i, .rst_ni, .we_i(we_en), .wdata_i(wdata_i), .q_o(en));

  irq_rw_reg #(.W(1), .MASK(1'b1)) u_ctrl (
    .clk_i, .rst_ni, .we_i(we_ctrl), .wdata_i(wdata_i[BIT_GLOBAL_EN]), .q_o(ctrl));

  irq_combine #(.W(W)) u_comb (
    .clk_i, .rst_ni, .stat_i(stat), .en_i(en), .gen_en_i(ctrl[0]), .irq_o(irq_o));

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: rdata_o[BIT_GLOBAL_EN] = ctrl[0];
      OFS_STAT: rdata_o = stat;
      OFS_EN:   rdata_o = en;
      default:  rdata_o = '0;
    endcase
  end

  assert_rsvd_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~IMPL_MASK) == '0);
  assert_evt_map_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[BIT_WC_CORRUPT] |=> stat[BIT_WC_CORRUPT]);
endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
  localparam logic [31:0] MASK = 32'h007F_FFFF;
  logic clk = 0, rst_n = 0;
  logic [31:0] evt = 0, wdata = 0, rdata;
  logic we = 0, irq;
  logic [7:0] addr = 0;
  int n_chk = 0, n_fail = 0;
  bit [31:0] m_stat, m_en;
  bit m_gen;

  always #2.5 clk = ~clk;

  irq_aggregator uut (.clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .wr_en_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  // reference model: set has priority over write-1 clear
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_stat = 0; m_en = 0; m_gen = 0; end
    else begin
      bit [31:0] c;
      c = (we && addr == 8'h24) ? wdata : 32'h0;
      m_stat = (m_stat & ~c) | (evt & MASK);
      if (we && addr == 8'h28) m_en = wdata & MASK;
      if (we && addr == 8'h20) m_gen = wdata[0];
    end
  end

  function automatic bit [31:0] m_rd(input bit [7:0] a);
    case (a)
      8'h20: return {31'b0, m_gen};
      8'h24: return m_stat;
      8'h28: return m_en;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input bit [31:0] got, input bit [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // compare outputs to model, then drive the next cycle's inputs
  task automatic cyc(input bit [31:0] e, input bit w, input bit [7:0] a, input bit [31:0] d);
    @(negedge clk);
    chk("R5 irq", {31'b0, irq}, {31'b0, m_gen && ((m_stat & m_en) != 0)});
    chk("R8 rdata", rdata, m_rd(addr));
    evt = e; we = w; addr = a; wdata = d;
  endtask

  task automatic rd(input bit [7:0] a, input bit [31:0] exp, input string tag);
    cyc(0, 0, a, 0);
    #1 chk(tag, rdata, exp);
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R1 irq in reset", {31'b0, irq}, 0);
    rst_n = 1;
    rd(8'h24, 0, "R1 status");
    rd(8'h28, 0, "R1 enable");
    rd(8'h20, 0, "R1 ctrl");
    chk("R1 irq", {31'b0, irq}, 0);
    // R2 / R9 sticky set
    cyc(32'h1 << 22, 0, 8'h24, 0);
    cyc(0, 0, 8'h24, 0);
    repeat (3) cyc(0, 0, 8'h24, 0);
    rd(8'h24, 32'h0040_0000, "R2 R9 sticky bit22");
    cyc(32'h1 << 10, 0, 8'h24, 0);
    rd(8'h24, 32'h0040_0400, "R9 ecc bit10");
    // R6 global gate
    cyc(0, 1, 8'h28, 32'h0040_0000);
    cyc(0, 0, 8'h24, 0);
    #1 chk("R6 gated", {31'b0, irq}, 0);
    cyc(0, 1, 8'h20, 1);
    cyc(0, 0, 8'h24, 0);
    #1 chk("R5 irq high", {31'b0, irq}, 1);
    // R3 write 0 keeps, write 1 clears
    cyc(0, 1, 8'h24, 0);
    rd(8'h24, 32'h0040_0400, "R3 write0 keeps");
    cyc(0, 1, 8'h24, 32'h0040_0000);
    rd(8'h24, 32'h0000_0400, "R3 write1 clears");
    chk("R5 irq low", {31'b0, irq}, 0);
    // R4 set wins
    cyc(32'h1 << 21, 0, 8'h24, 0);
    cyc(32'h1 << 21, 1, 8'h24, 32'h0020_0000);
    rd(8'h24, 32'h0020_0400, "R4 set wins");
    // R7 reserved
    cyc(32'hFFFF_FFFF, 0, 8'h24, 0);
    rd(8'h24, MASK, "R7 status rsvd");
    cyc(0, 1, 8'h28, 32'hFFFF_FFFF);
    rd(8'h28, MASK, "R7 enable rsvd");
    // R8 unmapped
    cyc(0, 1, 8'h2C, 32'h0);
    cyc(0, 1, 8'h30, 32'h0);
    rd(8'h30, 0, "R8 unmapped read");
    rd(8'h28, MASK, "R8 enable untouched");
    rd(8'h24, MASK, "R8 status untouched");
    // random phase, model compared each cycle
    for (int i = 0; i < 2000; i++) begin
      bit [31:0] e;
      bit [7:0] a;
      e = (($urandom % 4) == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
      case ($urandom % 4)
        0: a = 8'h20; 1: a = 8'h24; 2: a = 8'h28; default: a = 8'h2C;
      endcase
      cyc(e, ($urandom % 3) == 0, a, $urandom);
    end
    cyc(0, 0, 8'h24, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule